// File: doc/BRIEF.md
# Interrupt presentation controller

This block is the per-processor presentation stage of a two-level interrupt controller. A source stage offers interrupts to it, each offer carrying a 24-bit source number and an 8-bit priority. The block holds at most one pending interrupt, drives a single interrupt line to its processor, and compares every offer against a processor priority threshold. It also holds a software-written inter-processor priority from which it can present a self-generated interrupt under a reserved source number.

Software drives four operations through a small command port: set the processor priority, set the inter-processor priority, accept the pending interrupt (which returns the state word) and end of interrupt. Offers that lose, and pending interrupts that are displaced, are not dropped. They go back to the source stage on a reject pulse that carries the source number. When the slot frees or the threshold is relaxed, a resend pulse asks the source stage to offer its rejected sources again. An end of interrupt is forwarded on its own pulse.

Top module: `ipu_present`

## Requirements
- R1: After reset the state word is zero (processor priority 0 in bits 31:24, source field 0 in bits 23:0, a zero source field meaning nothing pending), `irq_out` is low, `op_ready` is high and the inter-processor priority is 0xFF.
- R2: An offer is refused when its priority is not strictly below the processor priority, or when an interrupt is pending whose priority is less than or equal to the offered priority. A refused offer gives a reject pulse with its own source number one cycle later and leaves the state word unchanged.
- R3: An offer that is not refused rejects the pending source if there is one. It then latches the new source and priority and raises `irq_out`.
- R4: Accept (op code 2) returns the state word on `acc_data` with `acc_valid` for one cycle and lowers `irq_out`. The state word then becomes the pending priority in bits 31:24 with a zero source field.
- R5: End of interrupt (op code 3) issues `eoi_pulse` with bits 23:0 of the written word and loads bits 31:24 as the processor priority. If nothing is pending, a resend pulse follows on the next cycle, and `op_ready` is low in between.
- R6: Set processor priority (op code 0, value in bits 7:0) to a smaller value, while a source is pending whose priority is greater than or equal to the new value, clears the pending source, lowers `irq_out` and rejects that source.
- R7: Set processor priority to a value equal to or larger than the current one while nothing is pending issues a resend pulse.
- R8: Set inter-processor priority (op code 1, value in bits 7:0) to a value below the processor priority rejects any pending source. It then latches source `IPI_SRC` (default 2) with that priority and raises `irq_out`.
- R9: That inter-processor check does nothing when a pending interrupt has priority less than or equal to the inter-processor priority.
- R10: Every resend first runs the inter-processor check when the inter-processor priority is below the processor priority. A zero source field then gets `IPI_SRC` latched before the resend pulse.
- R11: A command takes precedence over an offer in the same cycle: `offer_ready` is low while `op_valid` is high. At most one of reject, resend and end-of-interrupt pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Offer from the source stage |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_ready | output | 1 | Offer taken at this edge when valid |
| op_valid | input | 1 | Command request |
| op_code | input | 2 | 0 set processor priority, 1 set inter-processor priority, 2 accept, 3 end of interrupt |
| op_data | input | 32 | Command operand |
| op_ready | output | 1 | Command taken at this edge when valid |
| acc_valid | output | 1 | Accept result valid |
| acc_data | output | 32 | State word returned by accept |
| irq_out | output | 1 | Interrupt line to the processor |
| state_word | output | 32 | Current processor priority and pending source |
| rej_pulse | output | 1 | Reject to the source stage |
| rej_src | output | 24 | Rejected source number |
| resend_pulse | output | 1 | Request to re-offer rejected sources |
| eoi_pulse | output | 1 | End of interrupt to the source stage |
| eoi_src | output | 24 | Source number being ended |

## Verification
Every result registers at the clock edge that takes the offer or command. State word, interrupt line, reject, end-of-interrupt and accept data therefore appear one cycle after the request. The only exception is the resend after an end of interrupt, which comes one cycle later still, while `op_ready` is low. The bench drives at the falling edge and releases the request at the next falling edge. A monitor samples every pulse at each falling edge and pops the expected item from a queue filled by the driver, so an event that lands one cycle early or late shows up as an out-of-order or missing item. The driver waits for `op_ready` before it compares the state word.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  localparam int unsigned IPU_PW = 8;
  localparam int unsigned IPU_SW = 24;
  localparam int unsigned IPU_WW = IPU_PW + IPU_SW;

  typedef logic [IPU_PW-1:0] prio_t;
  typedef logic [IPU_SW-1:0] src_t;
  typedef logic [IPU_WW-1:0] word_t;

  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } ipu_op_e;

  // offer loses against threshold or against the pending one
  function automatic logic offer_loses(prio_t p, prio_t cur, logic busy, prio_t pend);
    return (p >= cur) || (busy && (pend <= p));
  endfunction

  // inter-processor check is held off by an equal or better pending one
  function automatic logic ipi_held(logic busy, prio_t pend, prio_t ipi);
    return busy && (pend <= ipi);
  endfunction

  function automatic word_t pack_word(prio_t c, src_t s);
    return {c, s};
  endfunction
endpackage

// File: rtl/ipu_decide.sv
module ipu_decide
  import ipu_pkg::*;
#(
  parameter src_t IPI_SRC = src_t'(2)
) (
  input  logic    take_op,
  input  ipu_op_e op_code,
  input  word_t   op_data,
  input  logic    take_offer,
  input  src_t    offer_src,
  input  prio_t   offer_prio,
  input  prio_t   cppr,
  input  src_t    xisr,
  input  prio_t   pend,
  input  prio_t   mfrr,
  input  logic    irq,
  output prio_t   n_cppr,
  output src_t    n_xisr,
  output prio_t   n_pend,
  output prio_t   n_mfrr,
  output logic    n_irq,
  output logic    rej_req,
  output src_t    rej_id,
  output logic    rs_now,
  output logic    rs_defer,
  output logic    eoi_req,
  output src_t    eoi_id,
  output logic    acc_req,
  output word_t   acc_word
);
  logic  busy;
  prio_t op_prio;
  prio_t op_top;

  assign busy    = (xisr != '0);
  assign op_prio = op_data[IPU_PW-1:0];
  assign op_top  = op_data[IPU_WW-1:IPU_SW];

  always_comb begin
    n_cppr   = cppr;
    n_xisr   = xisr;
    n_pend   = pend;
    n_mfrr   = mfrr;
    n_irq    = irq;
    rej_req  = 1'b0;
    rej_id   = '0;
    rs_now   = 1'b0;
    rs_defer = 1'b0;
    eoi_req  = 1'b0;
    eoi_id   = '0;
    acc_req  = 1'b0;
    acc_word = pack_word(cppr, xisr);
    if (take_op) begin
      unique case (op_code)
        OP_SET_CPPR: begin
          n_cppr = op_prio;
          if (op_prio < cppr) begin
            if (busy && (op_prio <= pend)) begin
              n_xisr  = '0;
              n_irq   = 1'b0;
              rej_req = 1'b1;
              rej_id  = xisr;
            end
          end else if (!busy) begin
            rs_now = 1'b1;
            if (mfrr < op_prio) begin
              n_xisr = IPI_SRC;
              n_pend = mfrr;
              n_irq  = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          n_mfrr = op_prio;
          if ((op_prio < cppr) && !ipi_held(busy, pend, op_prio)) begin
            if (busy) begin
              rej_req = 1'b1;
              rej_id  = xisr;
            end
            n_xisr = IPI_SRC;
            n_pend = op_prio;
            n_irq  = 1'b1;
          end
        end
        OP_ACCEPT: begin
          acc_req = 1'b1;
          n_irq   = 1'b0;
          n_cppr  = pend;
          n_xisr  = '0;
        end
        OP_EOI: begin
          eoi_req = 1'b1;
          eoi_id  = op_data[IPU_SW-1:0];
          n_cppr  = op_top;
          if (!busy) begin
            rs_defer = 1'b1;
            if (mfrr < op_top) begin
              n_xisr = IPI_SRC;
              n_pend = mfrr;
              n_irq  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (take_offer) begin
      if (offer_loses(offer_prio, cppr, busy, pend)) begin
        rej_req = 1'b1;
        rej_id  = offer_src;
      end else begin
        if (busy) begin
          rej_req = 1'b1;
          rej_id  = xisr;
        end
        n_xisr = offer_src;
        n_pend = offer_prio;
        n_irq  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipu_state_regs.sv
module ipu_state_regs
  import ipu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  prio_t n_cppr,
  input  src_t  n_xisr,
  input  prio_t n_pend,
  input  prio_t n_mfrr,
  input  logic  n_irq,
  output prio_t cppr,
  output src_t  xisr,
  output prio_t pend,
  output prio_t mfrr,
  output logic  irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr <= '0;
      xisr <= '0;
      pend <= '0;
      mfrr <= '1;
      irq  <= 1'b0;
    end else begin
      cppr <= n_cppr;
      xisr <= n_xisr;
      pend <= n_pend;
      mfrr <= n_mfrr;
      irq  <= n_irq;
    end
  end
endmodule

// File: rtl/ipu_event_out.sv
module ipu_event_out
  import ipu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rej_req,
  input  src_t  rej_id,
  input  logic  rs_now,
  input  logic  rs_defer,
  input  logic  eoi_req,
  input  src_t  eoi_id,
  input  logic  acc_req,
  input  word_t acc_word,
  output logic  rej_pulse,
  output src_t  rej_src,
  output logic  resend_pulse,
  output logic  eoi_pulse,
  output src_t  eoi_src,
  output logic  acc_valid,
  output word_t acc_data,
  output logic  defer_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_pulse    <= 1'b0;
      rej_src      <= '0;
      resend_pulse <= 1'b0;
      eoi_pulse    <= 1'b0;
      eoi_src      <= '0;
      acc_valid    <= 1'b0;
      acc_data     <= '0;
      defer_q      <= 1'b0;
    end else begin
      rej_pulse    <= rej_req;
      rej_src      <= rej_req ? rej_id : '0;
      resend_pulse <= rs_now | defer_q;
      eoi_pulse    <= eoi_req;
      eoi_src      <= eoi_req ? eoi_id : '0;
      acc_valid    <= acc_req;
      acc_data     <= acc_req ? acc_word : '0;
      defer_q      <= rs_defer;
    end
  end
endmodule

// File: rtl/ipu_present.sv
module ipu_present
  import ipu_pkg::*;
#(
  parameter src_t IPI_SRC = src_t'(2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  offer_valid,
  input  logic [IPU_SW-1:0]     offer_src,
  input  logic [IPU_PW-1:0]     offer_prio,
  output logic                  offer_ready,
  input  logic                  op_valid,
  input  logic [1:0]            op_code,
  input  logic [IPU_WW-1:0]     op_data,
  output logic                  op_ready,
  output logic                  acc_valid,
  output logic [IPU_WW-1:0]     acc_data,
  output logic                  irq_out,
  output logic [IPU_WW-1:0]     state_word,
  output logic                  rej_pulse,
  output logic [IPU_SW-1:0]     rej_src,
  output logic                  resend_pulse,
  output logic                  eoi_pulse,
  output logic [IPU_SW-1:0]     eoi_src
);
  prio_t cppr_q, pend_q, mfrr_q;
  src_t  xisr_q;
  logic  irq_q;
  prio_t n_cppr, n_pend, n_mfrr;
  src_t  n_xisr;
  logic  n_irq;
  logic  rej_req, rs_now, rs_defer, eoi_req, acc_req;
  src_t  rej_id, eoi_id;
  word_t acc_word;
  logic  defer_q;

  // named events for the checker
  logic ev_op_take, ev_offer_take, ev_offer_win, ev_offer_lose;

  assign op_ready      = !defer_q;
  assign offer_ready   = !defer_q && !op_valid;
  assign ev_op_take    = op_valid && op_ready;
  assign ev_offer_take = offer_valid && offer_ready;
  assign ev_offer_lose = ev_offer_take &&
                         offer_loses(offer_prio, cppr_q, xisr_q != '0, pend_q);
  assign ev_offer_win  = ev_offer_take && !ev_offer_lose;

  ipu_decide #(.IPI_SRC(IPI_SRC)) u_decide (
    .take_op   (ev_op_take),
    .op_code   (ipu_op_e'(op_code)),
    .op_data   (op_data),
    .take_offer(ev_offer_take),
    .offer_src (offer_src),
    .offer_prio(offer_prio),
    .cppr      (cppr_q),
    .xisr      (xisr_q),
    .pend      (pend_q),
    .mfrr      (mfrr_q),
    .irq       (irq_q),
    .n_cppr    (n_cppr),
    .n_xisr    (n_xisr),
    .n_pend    (n_pend),
    .n_mfrr    (n_mfrr),
    .n_irq     (n_irq),
    .rej_req   (rej_req),
    .rej_id    (rej_id),
    .rs_now    (rs_now),
    .rs_defer  (rs_defer),
    .eoi_req   (eoi_req),
    .eoi_id    (eoi_id),
    .acc_req   (acc_req),
    .acc_word  (acc_word)
  );

  ipu_state_regs u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .n_cppr(n_cppr),
    .n_xisr(n_xisr),
    .n_pend(n_pend),
    .n_mfrr(n_mfrr),
    .n_irq (n_irq),
    .cppr  (cppr_q),
    .xisr  (xisr_q),
    .pend  (pend_q),
    .mfrr  (mfrr_q),
    .irq   (irq_q)
  );

  ipu_event_out u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .rej_req     (rej_req),
    .rej_id      (rej_id),
    .rs_now      (rs_now),
    .rs_defer    (rs_defer),
    .eoi_req     (eoi_req),
    .eoi_id      (eoi_id),
    .acc_req     (acc_req),
    .acc_word    (acc_word),
    .rej_pulse   (rej_pulse),
    .rej_src     (rej_src),
    .resend_pulse(resend_pulse),
    .eoi_pulse   (eoi_pulse),
    .eoi_src     (eoi_src),
    .acc_valid   (acc_valid),
    .acc_data    (acc_data),
    .defer_q     (defer_q)
  );

  assign irq_out    = irq_q;
  assign state_word = pack_word(cppr_q, xisr_q);
endmodule

// File: rtl/ipu_chk.sv
module ipu_chk
  import ipu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ev_offer_win,
  input logic        ev_offer_lose,
  input logic [23:0] offer_src,
  input logic        op_valid,
  input logic        offer_ready,
  input logic        op_ready,
  input logic        irq_out,
  input logic [31:0] state_word,
  input logic        acc_valid,
  input logic        rej_pulse,
  input logic [23:0] rej_src,
  input logic        resend_pulse,
  input logic        eoi_pulse
);
  // R2: a losing offer comes back with its own number, state untouched
  p_lose_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_offer_lose |=> rej_pulse && (rej_src == $past(offer_src)) && $stable(state_word));

  // R3: a winning offer is latched and the line goes high
  p_win_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_offer_win |=> irq_out && (state_word[23:0] == $past(offer_src)));

  // R3 / R6: line high exactly when a source is pending
  p_line_tracks_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (state_word[23:0] != 24'd0));

  // R4: accept result comes with the line low and the slot empty
  p_accept_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !irq_out && (state_word[23:0] == 24'd0));

  // R5: a held-off command slot after end of interrupt means a resend is next
  p_eoi_then_resend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && !op_ready) |=> resend_pulse);

  // R11: command has precedence, and events leave one per cycle
  p_op_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !offer_ready);
  p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rej_pulse, resend_pulse, eoi_pulse}));
endmodule

bind ipu_present ipu_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_offer_win (ev_offer_win),
  .ev_offer_lose(ev_offer_lose),
  .offer_src    (offer_src),
  .op_valid     (op_valid),
  .offer_ready  (offer_ready),
  .op_ready     (op_ready),
  .irq_out      (irq_out),
  .state_word   (state_word),
  .acc_valid    (acc_valid),
  .rej_pulse    (rej_pulse),
  .rej_src      (rej_src),
  .resend_pulse (resend_pulse),
  .eoi_pulse    (eoi_pulse)
);

// File: tb/sim_ipu_present.sv
module sim_ipu_present;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] IPI = 24'd2;
  localparam logic [3:0] K_REJ = 4'd1, K_RS = 4'd2, K_EOI = 4'd3, K_ACC = 4'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        offer_ready;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        op_ready, acc_valid, irq_out;
  logic [31:0] acc_data, state_word;
  logic        rej_pulse, resend_pulse, eoi_pulse;
  logic [23:0] rej_src, eoi_src;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model of the state
  logic [7:0]  m_cppr = 8'h00, m_pend = 8'h00, m_mfrr = 8'hFF;
  logic [23:0] m_src = '0;
  logic        m_irq = 1'b0;

  logic [35:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipu_present u0 (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .offer_ready(offer_ready),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data), .op_ready(op_ready),
    .acc_valid(acc_valid), .acc_data(acc_data), .irq_out(irq_out),
    .state_word(state_word),
    .rej_pulse(rej_pulse), .rej_src(rej_src), .resend_pulse(resend_pulse),
    .eoi_pulse(eoi_pulse), .eoi_src(eoi_src)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] k, input logic [31:0] v, input string tag);
    exp_q.push_back({k, v});
    tag_q.push_back(tag);
  endtask

  task automatic ipi_check(input string tag);
    if (m_src != 0 && m_pend <= m_mfrr) return;
    if (m_src != 0) push(K_REJ, {8'h0, m_src}, tag);
    m_src = IPI; m_pend = m_mfrr; m_irq = 1'b1;
  endtask

  task automatic model_resend(input string tag);
    if (m_mfrr < m_cppr) ipi_check(tag);
    push(K_RS, 32'h0, tag);
  endtask

  task automatic model_op(input logic [1:0] c, input logic [31:0] d, input string tag);
    logic [7:0] v;
    v = d[7:0];
    case (c)
      2'd0: begin
        if (v < m_cppr) begin
          m_cppr = v;
          if (m_src != 0 && v <= m_pend) begin
            push(K_REJ, {8'h0, m_src}, tag);
            m_src = 0; m_irq = 1'b0;
          end
        end else begin
          m_cppr = v;
          if (m_src == 0) model_resend(tag);
        end
      end
      2'd1: begin
        m_mfrr = v;
        if (v < m_cppr) ipi_check(tag);
      end
      2'd2: begin
        push(K_ACC, {m_cppr, m_src}, tag);
        m_irq = 1'b0; m_cppr = m_pend; m_src = 0;
      end
      default: begin
        push(K_EOI, {8'h0, d[23:0]}, tag);
        m_cppr = d[31:24];
        if (m_src == 0) model_resend(tag);
      end
    endcase
  endtask

  task automatic model_offer(input logic [23:0] s, input logic [7:0] p, input string tag);
    if (p >= m_cppr || (m_src != 0 && m_pend <= p)) begin
      push(K_REJ, {8'h0, s}, tag);
    end else begin
      if (m_src != 0) push(K_REJ, {8'h0, m_src}, tag);
      m_src = s; m_pend = p; m_irq = 1'b1;
    end
  endtask

  task automatic check_state(input string tag);
    check({tag, " word"}, state_word, {m_cppr, m_src});
    check({tag, " irq"}, {31'h0, irq_out}, {31'h0, m_irq});
  endtask

  task automatic do_op(input logic [1:0] c, input logic [31:0] d, input string tag);
    model_op(c, d, tag);
    op_valid = 1'b1; op_code = c; op_data = d;
    @(negedge clk);
    op_valid = 1'b0;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic do_offer(input logic [23:0] s, input logic [7:0] p, input string tag);
    model_offer(s, p, tag);
    offer_valid = 1'b1; offer_src = s; offer_prio = p;
    @(negedge clk);
    offer_valid = 1'b0;
    @(negedge clk);
    check_state(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rej_pulse)    compare({K_REJ, 8'h0, rej_src});
      if (resend_pulse) compare({K_RS, 32'h0});
      if (eoi_pulse)    compare({K_EOI, 8'h0, eoi_src});
      if (acc_valid)    compare({K_ACC, acc_data});
    end
  end

  task automatic compare(input logic [35:0] got);
    logic [35:0] want;
    string t;
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL unexpected event actual=%h expected=none (R11)", got);
    end else begin
      want = exp_q.pop_front();
      t = tag_q.pop_front();
      if (got !== want) begin
        bad++;
        $display("FAIL %s event actual=%h expected=%h", t, got, want);
      end
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 word", state_word, 32'h0);
    check("R1 irq", {31'h0, irq_out}, 32'h0);
    check("R1 ready", {31'h0, op_ready}, 32'h1);

    do_offer(24'd100, 8'd5, "R2 threshold");
    do_op(2'd0, 32'h10, "R7 raise threshold");
    do_offer(24'd100, 8'd8, "R3 first win");
    do_offer(24'd101, 8'd9, "R2 pending better");
    do_offer(24'd102, 8'd4, "R3 displace");
    do_op(2'd1, 32'h06, "R9 ipi held");
    do_op(2'd1, 32'h03, "R8 ipi displaces");
    do_op(2'd2, 32'h0, "R4 accept ipi");
    do_op(2'd3, 32'h10000002, "R10 eoi re-ipi");
    do_op(2'd2, 32'h0, "R4 accept again");
    do_op(2'd1, 32'hFF, "R8 ipi off");
    do_op(2'd3, 32'h20000002, "R5 eoi resend");
    do_offer(24'd200, 8'd7, "R3 new win");
    do_op(2'd0, 32'h05, "R6 lower threshold");
    do_op(2'd0, 32'h06, "R7 larger");
    do_op(2'd0, 32'h06, "R7 equal");

    // R11: command and offer together, command first
    model_op(2'd0, 32'h30, "R11 op first");
    model_offer(24'd300, 8'd1, "R11 offer after");
    op_valid = 1'b1; op_code = 2'd0; op_data = 32'h30;
    offer_valid = 1'b1; offer_src = 24'd300; offer_prio = 8'd1;
    #1;
    check("R11 offer held", {31'h0, offer_ready}, 32'h0);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    check("R11 offer now", {31'h0, offer_ready}, 32'h1);
    @(negedge clk);
    offer_valid = 1'b0;
    @(negedge clk);
    check_state("R11 final");

    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule